// File: doc/BRIEF.md
# Dual-Clock Bidirectional Mailbox Pair

The block carries single words between two independent clock domains, port A and port B, through two mailbox registers. Mailbox 1 is written from port A and read from port B. Mailbox 2 is written from port B and read from port A. Each mailbox has an active-low full flag in its writer's domain. A write sets the flag, and further writes are refused while it is set. A read from the other domain returns the word and clears the flag.

The flag state crosses domains through a toggle handshake and a synchronizer chain of configurable depth. No set or clear event is lost, whatever the ratio between the two clocks. Each port has an enable, a direction select, a mailbox select, a data input, a registered data output and an output-enable. A partial reset empties both mailboxes. Each port reset empties the mailbox that port writes and zeroes that port's output register.

Top module: `mbox_pair`

## Requirements
- R1: A port-A edge with `en_a_i=1`, `mbx_a_i=1`, `wr_a_i=1` while `full1_n_o=1` loads `din_a_i` into mailbox 1 and drives `full1_n_o` low right after that edge. A port-B edge with `en_b_i=1`, `mbx_b_i=1`, `rnw_b_i=0` while `full2_n_o=1` does the same for mailbox 2 and `full2_n_o`.
- R2: A write to a mailbox whose flag is low is ignored, so the word held stays the first one written.
- R3: Once a written word has passed the synchronizer (SYNC_STAGES reader edges), a read on the reader port with enable and mailbox select high loads the word into that port's data output register on that edge.
- R4: A read that loads a word clears the mailbox, and the writer's flag returns high within SYNC_STAGES+2 writer clock edges.
- R5: Direction encoding: on port A, `wr_a_i=1` is write and `wr_a_i=0` is read. On port B, `rnw_b_i=0` is write and `rnw_b_i=1` is read.
- R6: `oe_a_o` is low whenever port A selects write (`wr_a_i=1`) and high otherwise. `oe_b_o` is low whenever port B selects write (`rnw_b_i=0`) and high otherwise.
- R7: With the port enable low or the mailbox select low, an edge neither writes nor reads a mailbox.
- R8: A read of an empty mailbox leaves the port's data output unchanged.
- R9: `prst_ni` low empties both mailboxes, drives both flags high and zeroes both data outputs.
- R10: `rst_a_ni` low empties mailbox 1, drives `full1_n_o` high and zeroes `dout_a_o`, and leaves mailbox 2 and its flag untouched. `rst_b_ni` acts the same way on mailbox 2 and `dout_b_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a_i | input | 1 | Port A clock |
| rst_a_ni | input | 1 | Port A asynchronous reset, active low |
| clk_b_i | input | 1 | Port B clock |
| rst_b_ni | input | 1 | Port B asynchronous reset, active low |
| prst_ni | input | 1 | Partial reset of both mailboxes, active low |
| en_a_i | input | 1 | Port A enable |
| wr_a_i | input | 1 | Port A direction, 1 = write, 0 = read |
| mbx_a_i | input | 1 | Port A mailbox select |
| din_a_i | input | W | Port A write data (to mailbox 1) |
| dout_a_o | output | W | Port A read data (from mailbox 2) |
| oe_a_o | output | 1 | Port A output enable |
| full1_n_o | output | 1 | Mailbox 1 full flag, active low, port A domain |
| en_b_i | input | 1 | Port B enable |
| rnw_b_i | input | 1 | Port B direction, 0 = write, 1 = read |
| mbx_b_i | input | 1 | Port B mailbox select |
| din_b_i | input | W | Port B write data (to mailbox 2) |
| dout_b_o | output | W | Port B read data (from mailbox 1) |
| oe_b_o | output | 1 | Port B output enable |
| full2_n_o | output | 1 | Mailbox 2 full flag, active low, port B domain |

## Verification
The bench builds the block with the full 36-bit data width and SYNC_STAGES=3. The deeper chain stretches the write-to-read and read-to-release latencies, so the waits in the bench must cover a crossing longer than the minimum. The two clocks run at unrelated periods, so handshake events land at varying phases. The 36-bit width lets data patterns touch the top and bottom bits. The bench exercises blocked writes, empty reads and each reset against words still in flight.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  typedef enum logic {
    DIR_READ  = 1'b0,
    DIR_WRITE = 1'b1
  } dir_e;
endpackage

// File: rtl/mbox_sync.sv
module mbox_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= d_i;
    end else begin : g_multi
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/mbox_channel.sv
module mbox_channel #(
  parameter int unsigned W           = 36,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         wclk_i,
  input  logic         rclk_i,
  input  logic         ch_rst_ni,   // clears flag, toggles and content
  input  logic         out_rst_ni,  // clears reader output register
  input  logic         wr_req_i,
  input  logic [W-1:0] din_i,
  input  logic         rd_req_i,
  output logic         full_n_o,
  output logic [W-1:0] dout_o
);
  logic         set_tgl_q, clr_tgl_q;
  logic         set_sync, clr_sync;
  logic         full_w, full_r, wr_fire, rd_fire;
  logic [W-1:0] data_q, rdata_q;

  // writer domain
  assign full_w  = set_tgl_q ^ clr_sync;
  assign wr_fire = wr_req_i & ~full_w;

  always_ff @(posedge wclk_i or negedge ch_rst_ni)
    if (!ch_rst_ni) begin
      set_tgl_q <= 1'b0;
      data_q    <= '0;
    end else if (wr_fire) begin
      set_tgl_q <= ~set_tgl_q;
      data_q    <= din_i;
    end

  mbox_sync #(.STAGES(SYNC_STAGES)) u_set_sync (
    .clk_i (rclk_i), .rst_ni(ch_rst_ni), .d_i(set_tgl_q), .q_o(set_sync)
  );

  // reader domain; data_q is stable once the set toggle is seen
  assign full_r  = set_sync ^ clr_tgl_q;
  assign rd_fire = rd_req_i & full_r;

  always_ff @(posedge rclk_i or negedge ch_rst_ni)
    if (!ch_rst_ni)   clr_tgl_q <= 1'b0;
    else if (rd_fire) clr_tgl_q <= ~clr_tgl_q;

  always_ff @(posedge rclk_i or negedge out_rst_ni)
    if (!out_rst_ni)  rdata_q <= '0;
    else if (rd_fire) rdata_q <= data_q;

  mbox_sync #(.STAGES(SYNC_STAGES)) u_clr_sync (
    .clk_i (wclk_i), .rst_ni(ch_rst_ni), .d_i(clr_tgl_q), .q_o(clr_sync)
  );

  assign full_n_o = ~full_w;
  assign dout_o   = rdata_q;

  p_set_on_write_r1: assert property (@(posedge wclk_i) disable iff (!ch_rst_ni)
    wr_fire |=> full_w);
  p_blocked_write_r2: assert property (@(posedge wclk_i) disable iff (!ch_rst_ni)
    (wr_req_i && full_w) |=> $stable(data_q));
  p_read_load_r3: assert property (@(posedge rclk_i) disable iff (!ch_rst_ni || !out_rst_ni)
    rd_fire |=> (rdata_q == $past(data_q)));
  p_read_clears_r4: assert property (@(posedge rclk_i) disable iff (!ch_rst_ni)
    rd_fire |=> !full_r);
  p_empty_hold_r8: assert property (@(posedge rclk_i) disable iff (!ch_rst_ni || !out_rst_ni)
    (rd_req_i && !full_r) |=> $stable(rdata_q));
endmodule

// File: rtl/mbox_pair.sv
module mbox_pair
  import mbox_pkg::*;
#(
  parameter int unsigned W           = 36,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk_a_i,
  input  logic         rst_a_ni,
  input  logic         clk_b_i,
  input  logic         rst_b_ni,
  input  logic         prst_ni,
  input  logic         en_a_i,
  input  logic         wr_a_i,
  input  logic         mbx_a_i,
  input  logic [W-1:0] din_a_i,
  output logic [W-1:0] dout_a_o,
  output logic         oe_a_o,
  output logic         full1_n_o,
  input  logic         en_b_i,
  input  logic         rnw_b_i,
  input  logic         mbx_b_i,
  input  logic [W-1:0] din_b_i,
  output logic [W-1:0] dout_b_o,
  output logic         oe_b_o,
  output logic         full2_n_o
);
  dir_e dir_a, dir_b;
  logic sel_a, sel_b, rst_a_all_n, rst_b_all_n;

  assign dir_a = wr_a_i  ? DIR_WRITE : DIR_READ;
  assign dir_b = rnw_b_i ? DIR_READ  : DIR_WRITE;
  assign sel_a = en_a_i & mbx_a_i;
  assign sel_b = en_b_i & mbx_b_i;

  assign rst_a_all_n = rst_a_ni & prst_ni;
  assign rst_b_all_n = rst_b_ni & prst_ni;

  assign oe_a_o = (dir_a == DIR_READ);
  assign oe_b_o = (dir_b == DIR_READ);

  // mailbox 1: A -> B
  mbox_channel #(.W(W), .SYNC_STAGES(SYNC_STAGES)) u_mb1 (
    .wclk_i    (clk_a_i),
    .rclk_i    (clk_b_i),
    .ch_rst_ni (rst_a_all_n),
    .out_rst_ni(rst_b_all_n),
    .wr_req_i  (sel_a && dir_a == DIR_WRITE),
    .din_i     (din_a_i),
    .rd_req_i  (sel_b && dir_b == DIR_READ),
    .full_n_o  (full1_n_o),
    .dout_o    (dout_b_o)
  );

  // mailbox 2: B -> A
  mbox_channel #(.W(W), .SYNC_STAGES(SYNC_STAGES)) u_mb2 (
    .wclk_i    (clk_b_i),
    .rclk_i    (clk_a_i),
    .ch_rst_ni (rst_b_all_n),
    .out_rst_ni(rst_a_all_n),
    .wr_req_i  (sel_b && dir_b == DIR_WRITE),
    .din_i     (din_b_i),
    .rd_req_i  (sel_a && dir_a == DIR_READ),
    .full_n_o  (full2_n_o),
    .dout_o    (dout_a_o)
  );

  p_oe_a_r6: assert property (@(posedge clk_a_i) disable iff (!rst_a_ni)
    wr_a_i |-> !oe_a_o);
  p_oe_b_r6: assert property (@(posedge clk_b_i) disable iff (!rst_b_ni)
    !rnw_b_i |-> !oe_b_o);
endmodule

// File: tb/sim_mbox_pair.sv
module sim_mbox_pair;
  localparam int W = 36;
  localparam int SS = 3;
  localparam int CLK_A_PERIOD = 10;
  localparam int CLK_B_PERIOD = 14;
  localparam int WAIT = SS + 4;

  logic clk_a = 0, clk_b = 0;
  logic rst_a_ni = 0, rst_b_ni = 0, prst_ni = 1;
  logic en_a = 0, wr_a = 0, mbx_a = 0, en_b = 0, rnw_b = 1, mbx_b = 0;
  logic [W-1:0] din_a = '0, din_b = '0;
  logic [W-1:0] dout_a, dout_b;
  logic oe_a, oe_b, full1_n, full2_n;

  int checks = 0, failures = 0;
  logic [W-1:0] q_a[$], q_b[$];
  logic [W-1:0] last_a = '0, last_b = '0;
  event ev_a, ev_b;

  always #(CLK_A_PERIOD/2) clk_a = ~clk_a;
  always #(CLK_B_PERIOD/2) clk_b = ~clk_b;

  mbox_pair #(.W(W), .SYNC_STAGES(SS)) u0 (
    .clk_a_i(clk_a), .rst_a_ni(rst_a_ni), .clk_b_i(clk_b), .rst_b_ni(rst_b_ni),
    .prst_ni(prst_ni),
    .en_a_i(en_a), .wr_a_i(wr_a), .mbx_a_i(mbx_a), .din_a_i(din_a),
    .dout_a_o(dout_a), .oe_a_o(oe_a), .full1_n_o(full1_n),
    .en_b_i(en_b), .rnw_b_i(rnw_b), .mbx_b_i(mbx_b), .din_b_i(din_b),
    .dout_b_o(dout_b), .oe_b_o(oe_b), .full2_n_o(full2_n)
  );

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_a(input int n); repeat (n) @(negedge clk_a); endtask
  task automatic wait_b(input int n); repeat (n) @(negedge clk_b); endtask

  // driver: pushes accepted words to the reader's queue
  task automatic write_a(input logic [W-1:0] d);
    @(negedge clk_a);
    en_a = 1; wr_a = 1; mbx_a = 1; din_a = d;
    if (full1_n) q_b.push_back(d);
    @(negedge clk_a);
    en_a = 0; wr_a = 0;
  endtask

  task automatic write_b(input logic [W-1:0] d);
    @(negedge clk_b);
    en_b = 1; rnw_b = 0; mbx_b = 1; din_b = d;
    if (full2_n) q_a.push_back(d);
    @(negedge clk_b);
    en_b = 0; rnw_b = 1;
  endtask

  task automatic read_a();
    @(negedge clk_a);
    en_a = 1; wr_a = 0; mbx_a = 1;
    @(negedge clk_a);
    en_a = 0;
    -> ev_a;
  endtask

  task automatic read_b();
    @(negedge clk_b);
    en_b = 1; rnw_b = 1; mbx_b = 1;
    @(negedge clk_b);
    en_b = 0;
    -> ev_b;
  endtask

  // monitors: compare read data; empty queue means output must hold (R8)
  initial forever begin
    logic [W-1:0] e;
    @(ev_a);
    e = (q_a.size() != 0) ? q_a.pop_front() : last_a;
    chk(dout_a === e, "R3 R8 port A read data", dout_a, e);
    last_a = e;
  end

  initial forever begin
    logic [W-1:0] e;
    @(ev_b);
    e = (q_b.size() != 0) ? q_b.pop_front() : last_b;
    chk(dout_b === e, "R3 R8 port B read data", dout_b, e);
    last_b = e;
  end

  initial begin
    #(CLK_A_PERIOD * 20000);
    chk(1'b0, "watchdog", '0, '1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait_a(3); wait_b(3);
    rst_a_ni = 1; rst_b_ni = 1;
    wait_a(2); wait_b(2);
    // R10 reset state
    chk(full1_n === 1'b1, "R10 reset full1_n", W'(full1_n), W'(1));
    chk(full2_n === 1'b1, "R10 reset full2_n", W'(full2_n), W'(1));
    chk(dout_a === '0 && dout_b === '0, "R10 reset outputs", dout_a | dout_b, '0);

    // R1 R5 port A write
    write_a(36'h8_1234_5671);
    chk(full1_n === 1'b0, "R1 R5 full1_n low after write", W'(full1_n), W'(0));
    // R2 blocked write
    write_a(36'hF_FFFF_FFFF);
    chk(full1_n === 1'b0, "R2 full1_n stays low", W'(full1_n), W'(0));
    wait_b(WAIT);
    read_b();
    wait_a(WAIT);
    chk(full1_n === 1'b1, "R4 full1_n released", W'(full1_n), W'(1));
    // R8 empty read
    read_b();

    // R7 gating
    @(negedge clk_a); en_a = 1; wr_a = 1; mbx_a = 0; din_a = 36'h5_5555_5555;
    @(negedge clk_a); en_a = 0; mbx_a = 1;
    @(negedge clk_a);
    chk(full1_n === 1'b1, "R7 mailbox select low ignored", W'(full1_n), W'(1));
    @(negedge clk_a); en_a = 0; wr_a = 1; mbx_a = 1;
    @(negedge clk_a); wr_a = 0;
    chk(full1_n === 1'b1, "R7 enable low ignored", W'(full1_n), W'(1));

    // R1 R5 port B write, read on A
    write_b(36'h0_0000_0001);
    chk(full2_n === 1'b0, "R1 R5 full2_n low after write", W'(full2_n), W'(0));
    wait_a(WAIT);
    read_a();
    wait_b(WAIT);
    chk(full2_n === 1'b1, "R4 full2_n released", W'(full2_n), W'(1));

    // R6 output enables
    @(negedge clk_a); wr_a = 1; #1;
    chk(oe_a === 1'b0, "R6 oe_a write", W'(oe_a), W'(0));
    wr_a = 0; #1;
    chk(oe_a === 1'b1, "R6 oe_a read", W'(oe_a), W'(1));
    @(negedge clk_b); rnw_b = 0; #1;
    chk(oe_b === 1'b0, "R6 oe_b write", W'(oe_b), W'(0));
    rnw_b = 1; #1;
    chk(oe_b === 1'b1, "R6 oe_b read", W'(oe_b), W'(1));

    // R10 port A reset with both mailboxes full
    write_a(36'hA_AAAA_0003);
    write_b(36'hB_BBBB_0004);
    wait_a(WAIT); wait_b(WAIT);
    @(negedge clk_a); rst_a_ni = 0;
    q_b.delete(); last_a = '0;
    wait_a(2); rst_a_ni = 1;
    wait_a(1);
    chk(full1_n === 1'b1, "R10 rst_a full1_n", W'(full1_n), W'(1));
    chk(dout_a === '0, "R10 rst_a dout_a", dout_a, '0);
    chk(full2_n === 1'b0, "R10 rst_a keeps mailbox 2", W'(full2_n), W'(0));
    wait_a(WAIT);
    read_a();
    read_b();
    wait_b(WAIT);

    // R9 partial reset
    write_a(36'h1_0000_0005);
    write_b(36'h2_0000_0006);
    wait_a(WAIT); wait_b(WAIT);
    @(negedge clk_a); prst_ni = 0;
    q_a.delete(); q_b.delete(); last_a = '0; last_b = '0;
    wait_a(2); prst_ni = 1;
    wait_a(1); wait_b(1);
    chk(full1_n === 1'b1 && full2_n === 1'b1, "R9 flags high", W'({full1_n, full2_n}), W'(3));
    chk(dout_a === '0 && dout_b === '0, "R9 outputs zero", dout_a | dout_b, '0);
    wait_b(WAIT);
    read_b();
    wait_a(2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule